// File: doc/BRIEF.md
# Sliding-Window Reuse Buffer

This block sits between a streaming memory reader and a group of parallel compute lanes that each work on a short run of consecutive array elements. Window number i holds elements i, i+1, i+2 and i+3, so neighbouring windows share three of their four elements. Each element is fetched from memory only once. The block keeps the elements that later windows still need and hands out every complete window in turn, together with its start index, so a consumer can tell which lane or thread the window belongs to. A run of N windows consumes N+3 input words. Fetching per window would cost 4N reads (103 against 400 for 100 windows).

Both data interfaces use valid/ready. A word on the input is taken in a cycle where `in_valid` and `in_ready` are both high. A window on the output is taken in a cycle where `out_valid` and `out_ready` are both high. While a finished window waits for the consumer, the block holds it unchanged and drops `in_ready`, so back-pressure reaches the source and no word is lost. If the consumer takes the window in the same cycle, a new word can enter in that cycle, giving one window per clock. The number of windows in a run comes from the plain input `cfg_win_count`, which must be at least 1 and stay stable during the run. After the last window is taken, `done` rises and the block accepts no more input until a synchronous reset.

Top module: `swb_window_buffer`

## Requirements
- R1: A synchronous reset (active-high `rst`) clears the stored words, the fill count and the window index: `out_valid`=0, `done`=0, `out_idx`=0, `out_data`=0 and `in_ready`=1 in the cycle after reset.
- R2: `out_valid` first rises in the cycle after the fourth input word has been accepted, and never before.
- R3: The window with start index i carries array element i+k in `out_data[k*DATA_W +: DATA_W]`, for k = 0..3. Array element j is the j-th word accepted after reset, counting from 0.
- R4: Windows leave in increasing start-index order 0, 1, 2, …. `out_idx` equals the start index of the window on offer.
- R5: Each accepted word after the fourth completes exactly one new window. A run of N windows consumes exactly N+3 input words.
- R6: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0, and `out_data` and `out_idx` keep their values until the window is taken.
- R7: While a window that is not the last of the run is on offer and `out_ready`=1, `in_ready` is 1. The word accepted in that cycle makes the next window valid in the following cycle, so a source and sink that are always willing get one window per clock.
- R8: After the window with index `cfg_win_count`-1 is taken, `done` is 1 and stays 1. `in_ready` and `out_valid` stay 0. Further input words change neither `out_data` nor `out_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_win_count | input | CNT_W | Number of windows in the run (at least 1) |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | DATA_W | Next array element of the stream |
| out_valid | output | 1 | A complete window is on offer |
| out_ready | input | 1 | Consumer takes the window |
| out_data | output | WIN*DATA_W | Window elements, lowest index in the lowest slot |
| out_idx | output | CNT_W | Start index of the window on offer |
| done | output | 1 | All windows of the run have been taken |

## Verification
Two events can fall in the same cycle: the consumer taking a held window, and a new word entering that completes the next window. The bench forces this with source and sink always willing, and also mixes random valid and ready patterns at several densities. It checks that a window is still offered in every following cycle, with the advanced index and the contents shifted by one element. The last window is the exception: taking it must not let a word in, and the bench confirms this by checking that `in_ready` stays low and that exactly N+3 words were consumed.

// File: rtl/swb_pkg.sv
package swb_pkg;
  // default geometry shared by the modules of the buffer
  parameter int unsigned SWB_DATA_W = 16;
  parameter int unsigned SWB_WIN    = 4;
  parameter int unsigned SWB_CNT_W  = 16;

  // width of a counter able to hold the value n
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/swb_shift_store.sv
module swb_shift_store #(
  parameter int unsigned DATA_W = swb_pkg::SWB_DATA_W,
  parameter int unsigned WIN    = swb_pkg::SWB_WIN
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic [DATA_W-1:0]     din,
  output logic [WIN*DATA_W-1:0] window_o
);
  logic [DATA_W-1:0] slot_q [WIN];

  for (genvar k = 0; k < WIN; k++) begin : g_slot
    if (k == WIN - 1) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)           slot_q[k] <= '0;
        else if (shift_en) slot_q[k] <= din;
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst)           slot_q[k] <= '0;
        else if (shift_en) slot_q[k] <= slot_q[k+1];
      end
    end
    assign window_o[k*DATA_W +: DATA_W] = slot_q[k];
  end
endmodule

// File: rtl/swb_fill_ctr.sv
module swb_fill_ctr #(
  parameter int unsigned WIN = swb_pkg::SWB_WIN
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  output logic primed_o
);
  localparam int unsigned FILL_W = swb_pkg::cnt_width(WIN - 1);
  localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(WIN - 1);

  logic [FILL_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst)                         fill_q <= '0;
    else if (inc && fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
  end

  // once WIN-1 words are stored, every new word closes a window
  assign primed_o = (fill_q == FILL_MAX);
endmodule

// File: rtl/swb_win_ctrl.sv
module swb_win_ctrl #(
  parameter int unsigned CNT_W = swb_pkg::SWB_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cfg_win_count,
  input  logic             in_valid,
  input  logic             out_ready,
  input  logic             primed,
  output logic             in_ready,
  output logic             accept,
  output logic             out_valid,
  output logic [CNT_W-1:0] out_idx,
  output logic             done
);
  logic             valid_q;
  logic             done_q;
  logic [CNT_W-1:0] idx_q;
  logic             last_win;
  logic             fire;

  assign last_win = (idx_q == cfg_win_count - 1'b1);
  assign fire     = valid_q && out_ready;
  assign in_ready = !done_q && !(valid_q && (!out_ready || last_win));
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
    end else begin
      if (accept && primed) valid_q <= 1'b1;
      else if (fire)        valid_q <= 1'b0;
      if (fire) begin
        if (last_win) done_q <= 1'b1;
        else          idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign out_valid = valid_q;
  assign out_idx   = idx_q;
  assign done      = done_q;
endmodule

// File: rtl/swb_window_buffer.sv
module swb_window_buffer #(
  parameter int unsigned DATA_W = swb_pkg::SWB_DATA_W,
  parameter int unsigned WIN    = swb_pkg::SWB_WIN,
  parameter int unsigned CNT_W  = swb_pkg::SWB_CNT_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [CNT_W-1:0]      cfg_win_count,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DATA_W-1:0]     in_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WIN*DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]      out_idx,
  output logic                  done
);
  logic accept;
  logic primed;

  swb_win_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .cfg_win_count(cfg_win_count),
    .in_valid(in_valid), .out_ready(out_ready), .primed(primed),
    .in_ready(in_ready), .accept(accept), .out_valid(out_valid),
    .out_idx(out_idx), .done(done)
  );

  swb_fill_ctr #(.WIN(WIN)) fill_i (
    .clk(clk), .rst(rst), .inc(accept), .primed_o(primed)
  );

  swb_shift_store #(.DATA_W(DATA_W), .WIN(WIN)) store_i (
    .clk(clk), .rst(rst), .shift_en(accept), .din(in_data), .window_o(out_data)
  );
endmodule

// File: rtl/swb_window_buffer_chk.sv
module swb_window_buffer_chk #(
  parameter int unsigned DATA_W = swb_pkg::SWB_DATA_W,
  parameter int unsigned WIN    = swb_pkg::SWB_WIN,
  parameter int unsigned CNT_W  = swb_pkg::SWB_CNT_W
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [WIN*DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]      out_idx,
  input logic                  done
);
  localparam int unsigned SEEN_W = swb_pkg::cnt_width(WIN);
  logic [SEEN_W-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= '0;
    else if (in_valid && in_ready && seen_q != SEEN_W'(WIN)) seen_q <= seen_q + 1'b1;
  end

  AST_FIRST_WINDOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (seen_q == SEEN_W'(WIN))); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (done || out_idx == CNT_W'($past(out_idx) + 1'b1))); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_idx))); // R6

  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!in_ready && !out_valid)); // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(out_data) && $stable(out_idx))); // R8
endmodule

bind swb_window_buffer swb_window_buffer_chk #(
  .DATA_W(DATA_W), .WIN(WIN), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_idx(out_idx), .done(done)
);

// File: tb/swb_window_buffer_tb_top.sv
`timescale 1ns/1ps
module swb_window_buffer_tb_top;
  localparam int DW = 16;
  localparam int WN = 4;
  localparam int CW = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [CW-1:0]      cfg_win_count = '0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [DW-1:0]      in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b0;
  logic [WN*DW-1:0]   out_data;
  logic [CW-1:0]      out_idx;
  logic               done;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] elem [0:255];

  always #2.5 clk = ~clk;

  swb_window_buffer #(.DATA_W(DW), .WIN(WN), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_win_count(cfg_win_count),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_idx(out_idx), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WN*DW-1:0] exp_window(input int start);
    logic [WN*DW-1:0] w;
    for (int k = 0; k < WN; k++) w[k*DW +: DW] = elem[start + k];
    return w;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(!out_valid && !done && out_idx == 0 && out_data == '0 && in_ready,
        "R1 reset state", {out_valid, done, in_ready}, 3'b001);
  endtask

  // one run of n windows; pin/pout are percent chances of valid/ready
  task automatic run_job(input int n, input int pin, input int pout);
    int acc_cnt = 0;
    int fired = 0;
    int cyc = 0;
    logic [WN*DW-1:0] held;
    for (int j = 0; j < 256; j++) elem[j] = DW'($urandom);
    cfg_win_count = CW'(n);
    do_reset();
    while (fired < n && cyc < 20000) begin
      bit avail;
      bit acc;
      bit fire;
      @(negedge clk);
      in_valid  = (($urandom % 100) < pin);
      out_ready = (($urandom % 100) < pout);
      in_data   = elem[acc_cnt];
      #1;
      avail = ((acc_cnt - (WN - 1)) - fired) > 0;
      chk(out_valid == avail, "R2/R5 window availability", out_valid, avail);
      if (out_valid) begin
        chk(out_idx == CW'(fired), "R4 window index", out_idx, fired);
        chk(out_data == exp_window(fired), "R3 window contents", out_data, exp_window(fired));
        if (!out_ready)
          chk(!in_ready, "R6 input blocked under back-pressure", in_ready, 0);
        else if (fired != n - 1)
          chk(in_ready, "R7 input open while window is taken", in_ready, 1);
        else
          chk(!in_ready, "R8 no input with last window", in_ready, 0);
      end
      acc  = in_valid && in_ready;
      fire = out_valid && out_ready;
      @(posedge clk);
      if (acc)  acc_cnt++;
      if (fire) fired++;
      cyc++;
    end
    @(negedge clk);
    #1;
    chk(done, "R8 done after last window", done, 1);
    chk(acc_cnt == n + WN - 1, "R5 words consumed", acc_cnt, n + WN - 1);
    held = out_data;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = DW'($urandom); out_ready = t[0];
      #1;
      chk(!in_ready && !out_valid && done, "R8 input ignored after done",
          {in_ready, out_valid, done}, 3'b001);
      chk(out_data == held && out_idx == CW'(n - 1), "R8 output unchanged after done",
          out_data, held);
    end
    in_valid = 1'b0;
  endtask

  // directed: source and sink always willing, one window per clock
  task automatic run_stream(input int n);
    int got = 0;
    for (int j = 0; j < 256; j++) elem[j] = DW'($urandom);
    cfg_win_count = CW'(n);
    do_reset();
    for (int t = 0; t < n + WN - 1; t++) begin
      @(negedge clk);
      in_valid = 1'b1; out_ready = 1'b1; in_data = elem[t];
      #1;
      chk(in_ready, "R7 input open in streaming", in_ready, 1);
      if (t >= WN) begin
        chk(out_valid && out_idx == CW'(got), "R7 window every clock", out_idx, got);
        chk(out_data == exp_window(got), "R3 streamed contents", out_data, exp_window(got));
        got++;
      end else begin
        chk(!out_valid, "R2 no window before fill", out_valid, 0);
      end
    end
    @(negedge clk);
    in_valid = 1'b1;
    #1;
    chk(out_valid && out_idx == CW'(n - 1) && !in_ready, "R8 last window blocks input",
        {out_valid, in_ready}, 2'b10);
    @(negedge clk);
    #1;
    chk(done && !out_valid, "R8 done after stream", done, 1);
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    run_job(100, 70, 60);   // mixed random flow
    run_job(1, 50, 50);     // single window run
    run_job(7, 100, 15);    // heavy back-pressure
    run_job(20, 20, 100);   // sparse source
    run_stream(12);         // full throughput and last-window boundary
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule